// File: doc/BRIEF.md
# I/O Window Address Translator

This block bridges a processor bus window to a legacy 16-bit I/O port space. The processor side issues one access at a time with an address, a size, a direction and write data. If the address falls inside an 8 MB window starting at 0x80000000, the block turns it into a port address and presents a port-side strobe. It holds that strobe until the device acknowledges, then returns a response that carries the read data.

Two address mappings are available, chosen by a mode input that is sampled when a request is accepted. Contiguous mode keeps only the low 16 address bits. Sparse mode keeps address bits 4:0 and moves the page-number bits 26:12 down by seven places, so that each group of 32 ports sits on its own 4 KB processor page.

A big-endian input, also sampled when the request is accepted, turns on byte-lane reversal for half-word and word data. The reversal is applied to the write data on the way out and to the read data on the way back, so a big-endian processor sees little-endian devices with their bytes in the right order.

Top module: `io_window_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and io_strobe_o, rsp_valid_o and rsp_miss_o are 0.
- R2: An accepted request whose address lies outside [0x80000000, 0x80800000) never raises io_strobe_o. Instead, on the next cycle, rsp_valid_o=1, rsp_miss_o=1 and rsp_rdata_o=0.
- R3: With sparse_mode_i=0 at acceptance, io_addr_o equals request address bits 15:0.
- R4: With sparse_mode_i=1 at acceptance, io_addr_o equals bits 15:0 of ((addr & 0x1F) | ((addr & 0x07FFF000) >> 7)).
- R5: One cycle after an in-window request is accepted, io_strobe_o=1, and io_addr_o, io_write_o, io_size_o and io_wdata_o carry the access. All of these stay stable until the cycle in which io_ack_i is sampled high.
- R6: From the cycle after an in-window request is accepted until its response, req_ready_o is 0, and any request presented in that period is ignored.
- R7: Size encoding: 0 is byte, 1 is half-word, 2 is word, and 3 is handled as word. A byte access passes all 32 data bits unchanged in both directions.
- R8: A half-word access with big_endian_i=1 swaps bytes 0 and 1 and leaves bits 31:16 unchanged, for both write and read data.
- R9: A word access (size 2 or 3) with big_endian_i=1 reverses all four bytes, for both write and read data.
- R10: With big_endian_i=0 at acceptance, data passes unchanged for every size.
- R11: The cycle after io_ack_i is sampled high with io_strobe_o=1, the block drives rsp_valid_o=1, rsp_miss_o=0, io_strobe_o=0 and req_ready_o=1. rsp_rdata_o holds the lane-adjusted read data for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian_i | input | 1 | Enables byte-lane reversal; sampled at acceptance |
| sparse_mode_i | input | 1 | 0 selects contiguous mapping, 1 selects sparse mapping; sampled at acceptance |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Processor address |
| req_size_i | input | 2 | Access size (0 byte, 1 half, 2 or 3 word) |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 32 | Processor write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_miss_o | output | 1 | Response belongs to an out-of-window request |
| rsp_rdata_o | output | 32 | Read data after lane adjustment |
| io_strobe_o | output | 1 | Port access in progress |
| io_write_o | output | 1 | Port access direction |
| io_size_o | output | 2 | Port access size |
| io_addr_o | output | 16 | Translated port address |
| io_wdata_o | output | 32 | Lane-adjusted write data |
| io_ack_i | input | 1 | Device completes the port access |
| io_rdata_i | input | 32 | Device read data, valid with io_ack_i |

## Verification
The response to one access and the acceptance of the next can fall in the same cycle: when rsp_valid_o pulses, req_ready_o is already high. The bench provokes this by driving a fresh request during the response cycle. It then checks that the first response carries the right data, that the new strobe and address appear on the following cycle, and that the response pulse has ended by then. A second overlap, a request arriving while a port access is still waiting for its acknowledge, is driven on purpose. It is judged by checking that the port address stays unchanged and that no extra strobe follows.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xact_state_e;

endpackage

// File: rtl/io_addr_map.sv
module io_addr_map #(
    parameter int              AW        = 32,
    parameter int              IO_AW     = 16,
    parameter logic [AW-1:0]   WIN_BASE  = 32'h8000_0000,
    parameter int              WIN_BYTES = 32'h0080_0000,
    parameter int              KEEP_BITS = 5,
    parameter int              PAGE_LSB  = 12,
    parameter int              PAGE_MSB  = 26,
    parameter int              PAGE_SHR  = 7
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             sparse_i,
    output logic             in_window_o,
    output logic [IO_AW-1:0] port_addr_o
);
    localparam int            WIN_LSB   = $clog2(WIN_BYTES);
    localparam logic [AW-1:0] KEEP_MASK = (AW'(1) << KEEP_BITS) - AW'(1);
    localparam logic [AW-1:0] HI_MASK   = ((AW'(1) << (PAGE_MSB + 1)) - AW'(1))
                                        & ~((AW'(1) << PAGE_LSB) - AW'(1));
    localparam logic [AW-WIN_LSB-1:0] WIN_TAG = WIN_BASE[AW-1:WIN_LSB];

    logic [IO_AW-1:0] flat_addr;
    logic [IO_AW-1:0] sparse_addr;

    // Window hit: compare the bits above the window size with the base.
    assign in_window_o = (addr_i[AW-1:WIN_LSB] == WIN_TAG);

    // Contiguous: plain truncation to the port space.
    assign flat_addr   = addr_i[IO_AW-1:0];

    // Sparse: keep the low port bits and pull the page number down.
    assign sparse_addr = IO_AW'((addr_i & KEEP_MASK) | ((addr_i & HI_MASK) >> PAGE_SHR));

    assign port_addr_o = sparse_i ? sparse_addr : flat_addr;

endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap
    import io_xlate_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] din_i,
    input  logic [1:0]    size_i,
    input  logic          swap_en_i,
    output logic [DW-1:0] dout_o
);
    localparam int NB = DW / 8;

    acc_size_e size_e;
    logic      rev_all;
    logic      rev_half;

    assign size_e   = acc_size_e'(size_i);
    assign rev_all  = swap_en_i && (size_e == SZ_WORD || size_e == SZ_WRSV);
    assign rev_half = swap_en_i && (size_e == SZ_HALF);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam int SRC_ALL  = NB - 1 - i;
        localparam int SRC_HALF = (i < 2) ? (1 - i) : i;
        always_comb begin
            if (rev_all) begin
                dout_o[8*i +: 8] = din_i[8*SRC_ALL +: 8];
            end else if (rev_half) begin
                dout_o[8*i +: 8] = din_i[8*SRC_HALF +: 8];
            end else begin
                dout_o[8*i +: 8] = din_i[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
    import io_xlate_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            DW        = 32,
    parameter int            IO_AW     = 16,
    parameter logic [AW-1:0] WIN_BASE  = 32'h8000_0000,
    parameter int            WIN_BYTES = 32'h0080_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             big_endian_i,
    input  logic             sparse_mode_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [1:0]       req_size_i,
    input  logic             req_write_i,
    input  logic [DW-1:0]    req_wdata_i,
    output logic             rsp_valid_o,
    output logic             rsp_miss_o,
    output logic [DW-1:0]    rsp_rdata_o,
    output logic             io_strobe_o,
    output logic             io_write_o,
    output logic [1:0]       io_size_o,
    output logic [IO_AW-1:0] io_addr_o,
    output logic [DW-1:0]    io_wdata_o,
    input  logic             io_ack_i,
    input  logic [DW-1:0]    io_rdata_i
);

    typedef struct packed {
        xact_state_e      state;
        logic             strobe;
        logic             write;
        logic [1:0]       size;
        logic             be;
        logic [IO_AW-1:0] addr;
        logic [DW-1:0]    wdata;
        logic             rsp_valid;
        logic             rsp_miss;
        logic [DW-1:0]    rsp_rdata;
    } xlate_regs_t;

    xlate_regs_t r_d, r_q;

    logic             accept;
    logic             hit;
    logic [IO_AW-1:0] port_addr;
    logic [DW-1:0]    wdata_lanes;
    logic [DW-1:0]    rdata_lanes;

    io_addr_map #(
        .AW        (AW),
        .IO_AW     (IO_AW),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) i_addr_map (
        .addr_i      (req_addr_i),
        .sparse_i    (sparse_mode_i),
        .in_window_o (hit),
        .port_addr_o (port_addr)
    );

    // Outbound lanes use the request's own size and endian setting.
    io_lane_swap #(.DW(DW)) i_wr_swap (
        .din_i     (req_wdata_i),
        .size_i    (req_size_i),
        .swap_en_i (big_endian_i),
        .dout_o    (wdata_lanes)
    );

    // Inbound lanes use the values captured at acceptance.
    io_lane_swap #(.DW(DW)) i_rd_swap (
        .din_i     (io_rdata_i),
        .size_i    (r_q.size),
        .swap_en_i (r_q.be),
        .dout_o    (rdata_lanes)
    );

    assign req_ready_o = (r_q.state == ST_IDLE);
    assign accept      = req_valid_i && req_ready_o;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_miss  = 1'b0;
        r_d.rsp_rdata = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        r_d.state  = ST_WAIT;
                        r_d.strobe = 1'b1;
                        r_d.write  = req_write_i;
                        r_d.size   = req_size_i;
                        r_d.be     = big_endian_i;
                        r_d.addr   = port_addr;
                        r_d.wdata  = wdata_lanes;
                    end else begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_miss  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (io_ack_i) begin
                    r_d.state     = ST_IDLE;
                    r_d.strobe    = 1'b0;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_rdata = r_q.write ? '0 : rdata_lanes;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid_o = r_q.rsp_valid;
    assign rsp_miss_o  = r_q.rsp_miss;
    assign rsp_rdata_o = r_q.rsp_rdata;
    assign io_strobe_o = r_q.strobe;
    assign io_write_o  = r_q.write;
    assign io_size_o   = r_q.size;
    assign io_addr_o   = r_q.addr;
    assign io_wdata_o  = r_q.wdata;

    // R2
    miss_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !hit) |=> (!io_strobe_o && rsp_valid_o && rsp_miss_o));

    // R3
    flat_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && hit && !sparse_mode_i)
        |=> (io_addr_o == $past(req_addr_i[IO_AW-1:0])));

    // R5
    hit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && hit) |=> io_strobe_o);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe_o && !io_ack_i) |=> (io_strobe_o && $stable(io_addr_o) && $stable(io_wdata_o)));

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe_o |-> !req_ready_o);

    // R11
    ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe_o && io_ack_i) |=> (rsp_valid_o && !rsp_miss_o && !io_strobe_o && req_ready_o));

endmodule

// File: tb/test_io_window_xlate.sv
module test_io_window_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        sparse_mode_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_addr_i = '0;
    logic [1:0]  req_size_i = '0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_wdata_i = '0;
    logic        rsp_valid_o;
    logic        rsp_miss_o;
    logic [31:0] rsp_rdata_o;
    logic        io_strobe_o;
    logic        io_write_o;
    logic [1:0]  io_size_o;
    logic [15:0] io_addr_o;
    logic [31:0] io_wdata_o;
    logic        io_ack_i = 1'b0;
    logic [31:0] io_rdata_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    io_window_xlate i_io_window_xlate (
        .clk           (clk),
        .rst_n         (rst_n),
        .big_endian_i  (big_endian_i),
        .sparse_mode_i (sparse_mode_i),
        .req_valid_i   (req_valid_i),
        .req_ready_o   (req_ready_o),
        .req_addr_i    (req_addr_i),
        .req_size_i    (req_size_i),
        .req_write_i   (req_write_i),
        .req_wdata_i   (req_wdata_i),
        .rsp_valid_o   (rsp_valid_o),
        .rsp_miss_o    (rsp_miss_o),
        .rsp_rdata_o   (rsp_rdata_o),
        .io_strobe_o   (io_strobe_o),
        .io_write_o    (io_write_o),
        .io_size_o     (io_size_o),
        .io_addr_o     (io_addr_o),
        .io_wdata_o    (io_wdata_o),
        .io_ack_i      (io_ack_i),
        .io_rdata_i    (io_rdata_i)
    );

    typedef struct packed {
        logic        sparse;
        logic        be;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] dev;
        logic        miss;
        logic [15:0] eaddr;
        logic [31:0] edata;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd0, 1'b1, 32'h8000_0398, 32'h1122_3344, 32'h0,          1'b0, 16'h0398, 32'h1122_3344},
        '{1'b0, 1'b1, 2'd1, 1'b1, 32'h8012_03F6, 32'hAABB_CCDD, 32'h0,          1'b0, 16'h03F6, 32'hAABB_DDCC},
        '{1'b0, 1'b1, 2'd2, 1'b0, 32'h807F_1F0C, 32'h0,         32'h0102_0304, 1'b0, 16'h1F0C, 32'h0403_0201},
        '{1'b1, 1'b1, 2'd0, 1'b0, 32'h8001_F016, 32'h0,         32'h5A00_00A5, 1'b0, 16'h03F6, 32'h5A00_00A5},
        '{1'b1, 1'b1, 2'd1, 1'b1, 32'h8007_FFFF, 32'h0000_BEEF, 32'h0,          1'b0, 16'h0FFF, 32'h0000_EFBE},
        '{1'b1, 1'b1, 2'd2, 1'b1, 32'h807F_F3E0, 32'hDEAD_BEEF, 32'h0,          1'b0, 16'hFFE0, 32'hEFBE_ADDE},
        '{1'b0, 1'b0, 2'd2, 1'b0, 32'h8040_1234, 32'h0,         32'hCAFE_F00D, 1'b0, 16'h1234, 32'hCAFE_F00D},
        '{1'b1, 1'b0, 2'd1, 1'b1, 32'h8000_2003, 32'h1234_5678, 32'h0,          1'b0, 16'h0043, 32'h1234_5678},
        '{1'b0, 1'b1, 2'd2, 1'b0, 32'h8080_0000, 32'h0,         32'h0,          1'b1, 16'h0000, 32'h0},
        '{1'b0, 1'b1, 2'd2, 1'b0, 32'h7FFF_FFFC, 32'h0,         32'h0,          1'b1, 16'h0000, 32'h0},
        '{1'b0, 1'b1, 2'd1, 1'b0, 32'h8000_0061, 32'h0,         32'h9988_7766, 1'b0, 16'h0061, 32'h9988_6677},
        '{1'b0, 1'b1, 2'd3, 1'b1, 32'h8000_0CF8, 32'h0123_4567, 32'h0,          1'b0, 16'h0CF8, 32'h6745_2301}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string data_req(input vec_t v);
        if (!v.be)            return "R10";
        else if (v.size == 0) return "R7";
        else if (v.size == 1) return "R8";
        else                  return "R9";
    endfunction

    task automatic drive_req(input vec_t v);
        req_valid_i   = 1'b1;
        sparse_mode_i = v.sparse;
        big_endian_i  = v.be;
        req_size_i    = v.size;
        req_write_i   = v.wr;
        req_addr_i    = v.addr;
        req_wdata_i   = v.wdata;
    endtask

    // Drive at a negedge; returns at the negedge after the response cycle.
    task automatic run_vec(input vec_t v);
        drive_req(v);
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        if (v.miss) begin
            // R2
            chk(rsp_valid_o && rsp_miss_o && !io_strobe_o, "R2", {29'b0, rsp_valid_o, rsp_miss_o, io_strobe_o}, 32'h6);
            chk(rsp_rdata_o == 32'h0, "R2", rsp_rdata_o, 32'h0);
            return;
        end
        chk(io_strobe_o && io_write_o == v.wr && io_size_o == v.size, "R5",
            {28'b0, io_strobe_o, io_write_o, io_size_o}, {28'b0, 1'b1, v.wr, v.size});
        chk(io_addr_o == v.eaddr, v.sparse ? "R4" : "R3", {16'b0, io_addr_o}, {16'b0, v.eaddr});
        if (v.wr) chk(io_wdata_o == v.edata, data_req(v), io_wdata_o, v.edata);
        // R6: a request offered while busy must be ignored
        req_valid_i = 1'b1;
        req_addr_i  = 32'h8000_0555;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(!req_ready_o && io_strobe_o && io_addr_o == v.eaddr, "R6", {16'b0, io_addr_o}, {16'b0, v.eaddr});
        @(posedge clk);
        @(negedge clk);
        chk(io_strobe_o && io_addr_o == v.eaddr, "R5", {16'b0, io_addr_o}, {16'b0, v.eaddr});
        io_ack_i   = 1'b1;
        io_rdata_i = v.dev;
        @(posedge clk);
        @(negedge clk);
        io_ack_i = 1'b0;
        chk(rsp_valid_o && !rsp_miss_o && !io_strobe_o && req_ready_o, "R11",
            {28'b0, rsp_valid_o, rsp_miss_o, io_strobe_o, req_ready_o}, 32'h9);
        if (v.wr) chk(rsp_rdata_o == 32'h0, "R11", rsp_rdata_o, 32'h0);
        else      chk(rsp_rdata_o == v.edata, data_req(v), rsp_rdata_o, v.edata);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(req_ready_o && !io_strobe_o && !rsp_valid_o && !rsp_miss_o, "R1",
            {28'b0, req_ready_o, io_strobe_o, rsp_valid_o, rsp_miss_o}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k]);
            @(negedge clk);
        end

        // R2: the response pulse of a miss lasts a single cycle, no strobe later
        run_vec(VECS[8]);
        @(negedge clk);
        chk(!rsp_valid_o && !io_strobe_o, "R2", {30'b0, rsp_valid_o, io_strobe_o}, 32'h0);

        // R11: a new request accepted in the response cycle
        run_vec(VECS[2]);
        drive_req(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(io_strobe_o && !rsp_valid_o && io_addr_o == 16'h0398, "R11",
            {15'b0, io_strobe_o, io_addr_o}, {15'b0, 1'b1, 16'h0398});
        io_ack_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_ack_i = 1'b0;
        chk(rsp_valid_o && req_ready_o, "R11", {30'b0, rsp_valid_o, req_ready_o}, 32'h3);

        // R10: sparse flat-vs-sparse mode sampled per request, no endian swap on read half
        run_vec('{1'b1, 1'b0, 2'd1, 1'b0, 32'h8000_3001, 32'h0, 32'hA1B2_C3D4, 1'b0, 16'h0061, 32'hA1B2_C3D4});
        @(negedge clk);

        finish_run();
    end

endmodule